// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block keeps an asynchronous DRAM alive. After reset it waits out the power-up pause that the memory requires. It then runs a fixed number of refresh cycles to initialise the memory's internal row counter. Once that is done it raises a ready flag and, from then on, asks for one refresh slot per programmed interval.

Each refresh is of the kind where CAS leads RAS, so the memory supplies the row address itself. No address leaves this block. Access to the memory pins is negotiated with the access controller through a request/grant pair. When a grant arrives, the block takes over the strobes through a mux select and drives its own RAS, CAS and WE pattern.

If the controller withholds the grant, periodic requests pile up in a small backlog that saturates at a set depth. Once the grant returns, the backlog is worked off back to back.

All time values are given in nanoseconds and converted into clock counts from the clock period parameter. Each count is rounded up.

Top module: `dram_rfsh_seq`

## Requirements
- R1: While reset is high and whenever `strobe_sel` is 0, `ras_n`, `cas_n` and `we_n` are 1. `ref_req` is 0 and `init_done` is 0 during reset.
- R2: `ref_req` stays 0 for the first PAUSE_CYC rising edges after reset is released, and is 1 after edge PAUSE_CYC, where PAUSE_CYC = ceil(PAUSE_NS / clock period).
- R3: Between the pause and `init_done`, exactly INIT_CYCLES refresh cycles are run, each through the handshake. `init_done` goes to 1 one clock after `strobe_sel` falls at the end of the last of them, and stays 1 until reset.
- R4: A refresh cycle starts on a rising edge where `ref_req` and `ref_gnt` are both 1. While the cycle runs, `ref_req` is 0 and `strobe_sel` is 1 for exactly CSR+CHR+max(RAS−CHR,1)+max(RP,RPC) clocks. Without a grant, no cycle starts.
- R5: `cas_n` is 0 for at least CSR clocks before `ras_n` falls, and stays 0 for at least CHR clocks after it.
- R6: `ras_n` stays 0 for at least RAS clocks. Between the rise of `ras_n` and its next fall, at least max(RP,RPC) clocks pass.
- R7: `we_n` is 1 throughout every refresh cycle.
- R8: After initialisation, with the grant always given, successive rises of `ref_req` are exactly INT_CYC clocks apart, where INT_CYC = ceil(INTERVAL_NS / clock period).
- R9: While the grant is withheld, up to BACKLOG_MAX due refreshes are kept and any beyond that are dropped. When the grant returns, exactly the kept number of cycles run back to back.
- R10: No interval is counted before `init_done`. The first periodic `ref_req` rises exactly INT_CYC clocks after `init_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh slot request |
| strobe_sel | output | 1 | Selects this block's strobes onto the memory pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| init_done | output | 1 | Memory ready for normal accesses |

## Verification
The bench keeps the 5 ns clock and the default strobe timings, so each refresh cycle is 18 clocks long, with RAS low for 10 of them. It shortens the power-up pause to 1000 ns and the refresh interval to 1000 ns, giving 200 clocks each. This brings the full initialisation, several periodic intervals and a backlog overflow held for more than five intervals within a few thousand cycles. The interval is long enough that four queued cycles drain between two ticks.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    // Strobe FSM state. Bit 0 = RAS active, bit 1 = CAS active, bit 2 = pins owned.
    // Each strobe comes straight from one state bit, so no decode glitches.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'b000,
        ST_CSETUP  = 3'b110,
        ST_BOTH    = 3'b111,
        ST_RASONLY = 3'b101,
        ST_PRECHG  = 3'b100
    } rfsh_state_e;

    typedef struct packed {
        logic sel;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } strobe_t;

    function automatic int ns_to_cyc(input int ns, input int clk_ps);
        return (ns * 1000 + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfsh_timebase.sv
module rfsh_timebase #(
    parameter int PAUSE_CYC = 40000,
    parameter int INT_CYC   = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic run_en,
    output logic pause_done,
    output logic tick
);
    localparam int PW = $clog2(PAUSE_CYC + 1);
    localparam int IW = $clog2(INT_CYC + 1);

    logic [PW-1:0] pause_cnt;
    logic [IW-1:0] int_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_cnt  <= '0;
            pause_done <= 1'b0;
        end else if (!pause_done) begin
            if (pause_cnt == PW'(PAUSE_CYC - 1))
                pause_done <= 1'b1;
            else
                pause_cnt <= pause_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run_en)
            int_cnt <= '0;
        else if (int_cnt == IW'(INT_CYC - 1))
            int_cnt <= '0;
        else
            int_cnt <= int_cnt + 1'b1;
    end

    assign tick = run_en && (int_cnt == IW'(INT_CYC - 1));

    // R10: interval ticks only once initialisation is complete
    p_tick_gated_r10: assert property (@(posedge clk) disable iff (rst)
        tick |-> (run_en && pause_done));

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic add,
    input  logic take,
    output logic has_work
);
    localparam int LW = $clog2(DEPTH + 1);

    logic [LW-1:0] level;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
        end else begin
            case ({add, take})
                2'b10:   if (level != LW'(DEPTH)) level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    assign has_work = (level != '0);

    // R9: backlog saturates at its depth
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        level <= LW'(DEPTH));

    // R9: a cycle is only taken from a non-empty backlog
    p_take_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
        take |-> has_work);

endmodule

// File: rtl/rfsh_cycle_fsm.sv
module rfsh_cycle_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int CSR_CYC = 2,
    parameter int CHR_CYC = 2,
    parameter int RAS_CYC = 10,
    parameter int PRE_CYC = 6
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output logic    idle,
    output logic    done,
    output strobe_t strb
);
    localparam int L_CSR   = imax(CSR_CYC, 1);
    localparam int L_BOTH  = imax(CHR_CYC, 1);
    localparam int L_RONLY = imax(RAS_CYC - L_BOTH, 1);
    localparam int L_PRE   = imax(PRE_CYC, 1);
    localparam int L_MAX   = imax(imax(L_CSR, L_BOTH), imax(L_RONLY, L_PRE));
    localparam int CW      = $clog2(L_MAX + 1);
    localparam int RLW     = $clog2(L_BOTH + L_RONLY + 1);

    rfsh_state_e   state;
    logic [CW-1:0] cnt;
    logic [RLW-1:0] ras_lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (state == ST_IDLE) begin
            if (start) begin
                state <= ST_CSETUP;
                cnt   <= CW'(L_CSR - 1);
            end
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end else begin
            case (state)
                ST_CSETUP:  begin state <= ST_BOTH;    cnt <= CW'(L_BOTH - 1);  end
                ST_BOTH:    begin state <= ST_RASONLY; cnt <= CW'(L_RONLY - 1); end
                ST_RASONLY: begin state <= ST_PRECHG;  cnt <= CW'(L_PRE - 1);   end
                default:    begin state <= ST_IDLE;    cnt <= '0;               end
            endcase
        end
    end

    // RAS low width tracker, used only by the width check
    always_ff @(posedge clk) begin
        if (rst || !state[0])
            ras_lo_cnt <= '0;
        else
            ras_lo_cnt <= ras_lo_cnt + 1'b1;
    end

    assign idle       = (state == ST_IDLE);
    assign done       = (state == ST_PRECHG) && (cnt == '0);
    assign strb.sel   = state[2];
    assign strb.ras_n = ~state[0];
    assign strb.cas_n = ~state[1];
    assign strb.we_n  = 1'b1;

    // R4: a new cycle only begins from idle
    p_start_idle_r4: assert property (@(posedge clk) disable iff (rst)
        start |-> idle);

    // R6: RAS low long enough when leaving the RAS-only phase
    p_ras_width_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RASONLY && cnt == '0) |-> (int'(ras_lo_cnt) + 1 >= RAS_CYC));

    // R5: RAS is never active without CAS having led it
    p_cbr_order_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BOTH) |-> ($past(state) == ST_CSETUP || $past(state) == ST_BOTH));

endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int CLK_PS      = 5000,
    parameter int PAUSE_NS    = 200000,
    parameter int INTERVAL_NS = 15000,
    parameter int INIT_CYCLES = 8,
    parameter int BACKLOG_MAX = 4,
    parameter int CSR_NS      = 10,
    parameter int CHR_NS      = 10,
    parameter int RAS_NS      = 50,
    parameter int RP_NS       = 30,
    parameter int RPC_NS      = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_gnt,
    output logic ref_req,
    output logic strobe_sel,
    output logic ras_n,
    output logic cas_n,
    output logic we_n,
    output logic init_done
);
    localparam int PAUSE_CYC = imax(ns_to_cyc(PAUSE_NS, CLK_PS), 1);
    localparam int INT_CYC   = imax(ns_to_cyc(INTERVAL_NS, CLK_PS), 2);
    localparam int CSR_CYC   = ns_to_cyc(CSR_NS, CLK_PS);
    localparam int CHR_CYC   = ns_to_cyc(CHR_NS, CLK_PS);
    localparam int RAS_CYC   = ns_to_cyc(RAS_NS, CLK_PS);
    localparam int PRE_CYC   = imax(ns_to_cyc(RP_NS, CLK_PS), ns_to_cyc(RPC_NS, CLK_PS));
    localparam int NW        = $clog2(INIT_CYCLES + 1);

    logic          pause_done, tick, has_work;
    logic          fsm_idle, fsm_done, start;
    logic          fin_q;
    logic [NW-1:0] init_cnt;
    strobe_t       strb;

    rfsh_timebase #(.PAUSE_CYC(PAUSE_CYC), .INT_CYC(INT_CYC)) u_time (
        .clk(clk), .rst(rst), .run_en(init_done),
        .pause_done(pause_done), .tick(tick));

    rfsh_backlog #(.DEPTH(BACKLOG_MAX)) u_backlog (
        .clk(clk), .rst(rst), .add(tick), .take(start && init_done),
        .has_work(has_work));

    rfsh_cycle_fsm #(.CSR_CYC(CSR_CYC), .CHR_CYC(CHR_CYC),
                     .RAS_CYC(RAS_CYC), .PRE_CYC(PRE_CYC)) u_fsm (
        .clk(clk), .rst(rst), .start(start),
        .idle(fsm_idle), .done(fsm_done), .strb(strb));

    assign ref_req = fsm_idle &&
                     ((pause_done && !init_done && (init_cnt < NW'(INIT_CYCLES))) ||
                      (init_done && has_work));
    assign start   = ref_req && ref_gnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            init_cnt  <= '0;
            fin_q     <= 1'b0;
            init_done <= 1'b0;
        end else begin
            if (start && !init_done && init_cnt < NW'(INIT_CYCLES))
                init_cnt <= init_cnt + 1'b1;
            fin_q     <= fsm_done && !init_done && (init_cnt == NW'(INIT_CYCLES));
            init_done <= init_done | fin_q;
        end
    end

    assign strobe_sel = strb.sel;
    assign ras_n      = strb.ras_n;
    assign cas_n      = strb.cas_n;
    assign we_n       = strb.we_n;

    // R2: nothing is requested during the power-up pause
    p_quiet_pause_r2: assert property (@(posedge clk) disable iff (rst)
        !pause_done |-> !ref_req);

    // R3: ready flag never drops once raised
    p_init_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R4: granted request turns into an owned cycle and the request drops
    p_req_drops_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> (!ref_req && strobe_sel));

    // R1: strobes idle whenever the pins are not owned
    p_idle_strobes_r1: assert property (@(posedge clk) disable iff (rst)
        !strobe_sel |-> (ras_n && cas_n && we_n));

    // R5: CAS already low on the edge before RAS falls
    p_cas_leads_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

endmodule

// File: tb/tb_dram_rfsh_seq.sv
`timescale 1ns/1ps
module tb_dram_rfsh_seq;

    localparam int CLK_PS   = 5000;
    localparam int P_CYC    = 200;
    localparam int I_CYC    = 200;
    localparam int N_INIT   = 8;
    localparam int QMAX     = 4;
    localparam int E_CSR    = 2;
    localparam int E_CHR    = 2;
    localparam int E_RAS    = 10;
    localparam int E_PRE    = 6;
    localparam int E_CYCLEN = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_gnt = 1'b0;
    logic ref_req, strobe_sel, ras_n, cas_n, we_n, init_done;

    int total = 0;
    int bad = 0;
    int gmode = 0;   // 0 = grant low, 1 = grant high, 2 = random
    int sample_no = 0;
    int nfall = 0;
    int sel_falls = 0;
    int last_sel_fall = 0;

    always #2.5 clk = ~clk;

    dram_rfsh_seq #(.CLK_PS(CLK_PS), .PAUSE_NS(1000), .INTERVAL_NS(1000),
                    .INIT_CYCLES(N_INIT), .BACKLOG_MAX(QMAX)) dut (
        .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req),
        .strobe_sel(strobe_sel), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .init_done(init_done));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit spacing_ok(input int got);
        return got == I_CYC;
    endfunction

    // grant driver
    initial begin
        void'($urandom(32'd1234));
        forever begin
            @(negedge clk);
            case (gmode)
                0: ref_gnt = 1'b0;
                1: ref_gnt = 1'b1;
                default: ref_gnt = (($urandom % 3) == 0);
            endcase
        end
    end

    // strobe monitor
    initial begin
        int cas_lo_run = 0, ras_lo_run = 0, ras_hi_run = 0, sel_run = 0, cas_after = 0;
        bit p_ras = 1, p_cas = 1, p_sel = 0;
        forever begin
            @(negedge clk);
            if (!rst) begin
                sample_no++;
                if (strobe_sel && !we_n) check(0, "R7 we_n", we_n, 1);
                if (!strobe_sel && (!ras_n || !cas_n))
                    check(0, "R1 strobes idle", {ras_n, cas_n}, 3);
                if (p_ras && !ras_n) begin
                    check(!cas_n && cas_lo_run >= E_CSR, "R5 cas lead", cas_lo_run, E_CSR);
                    if (nfall > 0) check(ras_hi_run >= E_PRE, "R6 precharge", ras_hi_run, E_PRE);
                    nfall++;
                    cas_after = 0;
                end
                if (!p_cas && cas_n && !ras_n)
                    check(cas_after >= E_CHR, "R5 cas hold", cas_after, E_CHR);
                if (!p_ras && ras_n)
                    check(ras_lo_run >= E_RAS, "R6 ras width", ras_lo_run, E_RAS);
                if (p_sel && !strobe_sel) begin
                    check(sel_run == E_CYCLEN, "R4 cycle length", sel_run, E_CYCLEN);
                    sel_falls++;
                    last_sel_fall = sample_no;
                end
                cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
                ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
                ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
                sel_run    = strobe_sel ? sel_run + 1 : 0;
                if (!ras_n && !cas_n) cas_after++;
                p_ras = ras_n; p_cas = cas_n; p_sel = strobe_sel;
            end
        end
    end

    // watchdog
    initial begin
        #(200000 * 5);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, s0, f0, r_prev;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(ras_n && cas_n && we_n && !strobe_sel, "R1 reset strobes",
              {ras_n, cas_n, we_n, strobe_sel}, 4'b1110);
        check(!ref_req && !init_done, "R1 reset flags", {ref_req, init_done}, 0);
        rst = 1'b0;

        // R2 pause length
        n = 0;
        do begin @(negedge clk); n++; end while (!ref_req && n < P_CYC + 20);
        check(n == P_CYC, "R2 pause edges", n, P_CYC);

        // R3 initialisation under random grants
        gmode = 2;
        n = 0;
        while (!init_done && n < 5000) begin @(negedge clk); n++; end
        check(nfall == N_INIT, "R3 init cycles", nfall, N_INIT);
        check(sel_falls == N_INIT, "R3 init owned cycles", sel_falls, N_INIT);
        check(sample_no - last_sel_fall == 1, "R3 done delay", sample_no - last_sel_fall, 1);

        // R10 first periodic request exactly one interval after init_done
        gmode = 1;
        s0 = sample_no;
        f0 = nfall;
        n = 0;
        while (!ref_req && n < 3 * I_CYC) begin @(negedge clk); n++; end
        check(sample_no - s0 == I_CYC, "R10 first request", sample_no - s0, I_CYC);
        check(nfall == f0, "R10 no early cycle", nfall - f0, 0);

        // R8 interval spacing with grant always given
        for (int k = 0; k < 3; k++) begin
            r_prev = sample_no;
            f0 = nfall;
            do @(negedge clk); while (ref_req);
            n = 0;
            while (!ref_req && n < 3 * I_CYC) begin @(negedge clk); n++; end
            check(spacing_ok(sample_no - r_prev), "R8 spacing", sample_no - r_prev, I_CYC);
            check(nfall - f0 == 1, "R8 one cycle per interval", nfall - f0, 1);
        end

        // R9 and R4: withhold grant across several intervals
        gmode = 0;
        do @(negedge clk); while (strobe_sel || ref_req);
        n = 0;
        while (!ref_req && n < 3 * I_CYC) begin @(negedge clk); n++; end
        f0 = nfall;
        repeat (5 * I_CYC + I_CYC / 2) @(negedge clk);
        check(nfall == f0, "R4 no cycle without grant", nfall - f0, 0);
        check(ref_req == 1'b1, "R9 request held", ref_req, 1);
        gmode = 1;
        repeat (90) @(negedge clk);
        check(nfall - f0 == QMAX, "R9 drained count", nfall - f0, QMAX);
        check(ref_req == 1'b0, "R9 backlog empty", ref_req, 0);

        // random grant phase; monitor keeps checking R4-R7
        gmode = 2;
        f0 = nfall;
        repeat (6 * I_CYC) @(negedge clk);
        check(nfall - f0 >= 5 && nfall - f0 <= 7, "R8 random grant rate", nfall - f0, 6);
        check(init_done == 1'b1, "R3 init sticky", init_done, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule